// File: doc/BRIEF.md
# Serial Receive FIFO with Programmable Trigger

This block is the receive half of a FIFO-based serial controller, seen from its register side. Bytes that a separate deserializer has already framed arrive on a one-cycle valid strobe and are kept in a 16-entry circular buffer. Software reads the data register to take bytes out in arrival order. A two-bit field picks a fill threshold of 1, 4, 8 or 14 bytes. When the fill level reaches the threshold, a data-ready status bit is set and, if enabled, a level-sensitive receive interrupt is raised.

The register bus is a single-cycle select/write strobe with a two-bit register index. It reaches four registers: control (index 0), status (index 1), receive data (index 2) and FIFO control (index 3). Read data is registered and appears on `reg_rdata` in the cycle after the read strobe is sampled. It holds until the next read. The interrupt and the status flags are cleared by writing zeros to status or control bits, as the requirements below state. A break indication from the line side is latched as a status bit.

Top module: `uart_rx_trigfifo`

## Requirements
- R1: After synchronous reset, control, status and FIFO-control read 0x00, the trigger level is 1, `rx_irq` is low and a data read returns 0x00.
- R2: A byte on `rx_data` with `rx_valid` high is stored only while control bit 4 (receive enable) is 1. Reads of register index 2 return the stored bytes in arrival order.
- R3: The buffer holds 16 bytes. A byte that arrives while 16 are held is dropped and the contents are unchanged.
- R4: FIFO-control bits 7:6 select the trigger level: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14. Status bit 1 (data-ready) is set when a stored byte brings the count to or above the level.
- R5: A data read that leaves the count below the trigger level clears status bit 1.
- R6: `rx_irq` goes high when a stored byte brings the count to or above the level while control bit 6 (interrupt enable) is 1. It stays high after the count falls, and it is not raised while bit 6 is 0.
- R7: A status write with bit 1 or bit 0 equal to 0 drops `rx_irq`. A status write with bit 1 equal to 0 clears data-ready. Status bit 0 (timeout flag) has no source here and reads 0.
- R8: A control write with bit 6 equal to 0 drops `rx_irq`. The control value is stored ANDed with 0xFA.
- R9: A FIFO-control write with bit 1 set empties the buffer and clears data-ready. Bit 1 is not stored and reads back 0.
- R10: A pulse on `rx_brk` sets status bit 4. A status write with bit 4 equal to 0 clears it.
- R11: A data read of an empty buffer returns 0x00 and changes nothing. A store and a data read in the same cycle leave the count unchanged.
- R12: The read and write positions wrap from entry 15 to entry 0, and the arrival order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register index: 0 control, 1 status, 2 data, 3 FIFO control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break detected pulse |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
The hardest state to reach is a full buffer whose read and write positions have already wrapped, together with a 17th arriving byte. The bench first moves both positions to entry 5 by storing and reading five bytes. It then fills all 16 entries, offers one more byte and drains the buffer, so the overflow drop and the wrap are both seen in the read order. A second hard case is a store and a read in the same cycle. The bench drives both strobes on one edge and then counts the remaining bytes to show the count did not move.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_FCTL = 2'd3
  } rxq_reg_e;

  // control bits
  localparam int unsigned CTRL_RXEN_BIT = 4;
  localparam int unsigned CTRL_RIE_BIT  = 6;
  localparam logic [7:0]  CTRL_WMASK    = 8'hFA;

  // status bits
  localparam int unsigned STAT_TMO_BIT  = 0;
  localparam int unsigned STAT_RDY_BIT  = 1;
  localparam int unsigned STAT_BRK_BIT  = 4;

  // fifo-control bits
  localparam int unsigned FCTL_FLUSH_BIT = 1;
  localparam logic [7:0]  FCTL_KEEP_MASK = 8'hFD;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  always_comb begin
    if (flush) begin
      cnt_nxt = '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   cnt_nxt = cnt + CW'(1);
        2'b01:   cnt_nxt = cnt - CW'(1);
        default: cnt_nxt = cnt;
      endcase
    end
  end

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= bump(wr_ptr);
        if (pop_ok)  rd_ptr <= bump(rd_ptr);
      end
    end
  end

  // registered read port; an empty read yields zero
  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop_ok) begin
      pop_data <= mem[rd_ptr];
    end else if (pop_req) begin
      pop_data <= '0;
    end
  end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] trig,
  input  logic          rie,
  input  logic          flush,
  input  logic          ctrl_wr,
  input  logic          ctrl_w_rie,
  input  logic          stat_wr,
  input  logic          stat_w_tmo,
  input  logic          stat_w_rdy,
  input  logic          stat_w_brk,
  input  logic          brk_in,
  output logic          rdy_q,
  output logic          irq_q,
  output logic          brk_q
);

  logic at_level;
  logic rdy_d, irq_d, brk_d;

  assign at_level = (cnt_nxt >= trig);

  always_comb begin
    rdy_d = rdy_q;
    if (flush) rdy_d = 1'b0;
    if (stat_wr && !stat_w_rdy) rdy_d = 1'b0;
    if (push_ok && at_level) begin
      rdy_d = 1'b1;
    end else if (pop_ok && !push_ok && !at_level) begin
      rdy_d = 1'b0;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (ctrl_wr && !ctrl_w_rie) irq_d = 1'b0;
    if (stat_wr && (!stat_w_rdy || !stat_w_tmo)) irq_d = 1'b0;
    if (push_ok && at_level && rie) irq_d = 1'b1;
  end

  always_comb begin
    brk_d = brk_q;
    if (stat_wr && !stat_w_brk) brk_d = 1'b0;
    if (brk_in) brk_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b0;
      irq_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      irq_q <= irq_d;
      brk_q <= brk_d;
    end
  end

endmodule

// File: rtl/uart_rx_trigfifo.sv
module uart_rx_trigfifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_brk,
  output logic       rx_irq
);
  import rxq_pkg::*;

  logic [7:0]       ctrl_q, fctl_q, rdata_q, pop_data;
  logic             rsel_data_q;
  logic             wr_en, rd_en;
  logic             ctrl_wr, stat_wr, fctl_wr, flush, data_rd;
  logic             push_ok, pop_ok, rdy_q, brk_flag;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, trig;

  assign wr_en   = reg_sel && reg_wr;
  assign rd_en   = reg_sel && !reg_wr;
  assign ctrl_wr = wr_en && (reg_addr == REG_CTRL);
  assign stat_wr = wr_en && (reg_addr == REG_STAT);
  assign fctl_wr = wr_en && (reg_addr == REG_FCTL);
  assign flush   = fctl_wr && reg_wdata[FCTL_FLUSH_BIT];
  assign data_rd = rd_en && (reg_addr == REG_DATA);
  assign trig    = CNT_W'(trig_level(fctl_q[7:6]));

  rxq_ring #(.DW(8), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push_req  (rx_valid && ctrl_q[CTRL_RXEN_BIT]),
    .push_data (rx_data),
    .pop_req   (data_rd),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .pop_data  (pop_data),
    .cnt       (cnt_q),
    .cnt_nxt   (cnt_nxt)
  );

  rxq_flags #(.CW(CNT_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .cnt_nxt    (cnt_nxt),
    .trig       (trig),
    .rie        (ctrl_q[CTRL_RIE_BIT]),
    .flush      (flush),
    .ctrl_wr    (ctrl_wr),
    .ctrl_w_rie (reg_wdata[CTRL_RIE_BIT]),
    .stat_wr    (stat_wr),
    .stat_w_tmo (reg_wdata[STAT_TMO_BIT]),
    .stat_w_rdy (reg_wdata[STAT_RDY_BIT]),
    .stat_w_brk (reg_wdata[STAT_BRK_BIT]),
    .brk_in     (rx_brk),
    .rdy_q      (rdy_q),
    .irq_q      (rx_irq),
    .brk_q      (brk_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      fctl_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata & CTRL_WMASK;
      if (fctl_wr) fctl_q <= reg_wdata & FCTL_KEEP_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q     <= '0;
      rsel_data_q <= 1'b0;
    end else if (rd_en) begin
      rsel_data_q <= (reg_addr == REG_DATA);
      case (reg_addr)
        REG_CTRL: rdata_q <= ctrl_q;
        REG_STAT: begin
          rdata_q               <= '0;
          rdata_q[STAT_RDY_BIT] <= rdy_q;
          rdata_q[STAT_BRK_BIT] <= brk_flag;
        end
        REG_FCTL: rdata_q <= fctl_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rsel_data_q ? pop_data : rdata_q;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          rx_valid,
  input logic          rx_brk,
  input logic          rx_irq,
  input logic          rie,
  input logic          brk_flag,
  input logic [CW-1:0] cnt
);
  import rxq_pkg::*;

  logic rd_data, flush_wr, ctrl_clr, stat_clr;
  assign rd_data  = reg_sel && !reg_wr && (reg_addr == REG_DATA);
  assign flush_wr = reg_sel && reg_wr && (reg_addr == REG_FCTL) && reg_wdata[1];
  assign ctrl_clr = reg_sel && reg_wr && (reg_addr == REG_CTRL) && !reg_wdata[6];
  assign stat_clr = reg_sel && reg_wr && (reg_addr == REG_STAT) &&
                    (!reg_wdata[1] || !reg_wdata[0]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH) && !rd_data && !flush_wr) |=> cnt == CW'(DEPTH));

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush_wr |=> cnt == '0);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && rd_data && !rx_valid) |=> cnt == '0);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_irq && !ctrl_clr && !stat_clr) |=> rx_irq);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq) |-> $past(rx_valid && rie));

  p_irq_stat_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !rx_valid) |=> !rx_irq);

  p_irq_ctrl_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_clr && !rx_valid) |=> !rx_irq);

  p_break_set_r10: assert property (@(posedge clk) disable iff (rst)
    rx_brk |=> brk_flag);

endmodule

bind uart_rx_trigfifo rxq_checker #(.DEPTH(DEPTH), .CW(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_valid  (rx_valid),
  .rx_brk    (rx_brk),
  .rx_irq    (rx_irq),
  .rie       (ctrl_q[6]),
  .brk_flag  (brk_flag),
  .cnt       (cnt_q)
);

// File: tb/uart_rx_trigfifo_bench.sv
`timescale 1ns/1ps
module uart_rx_trigfifo_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_sel = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_FCTL = 2'd3;

  always #2.5 clk = ~clk;

  uart_rx_trigfifo u_uart_rx_trigfifo (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irq", {7'd0, rx_irq}, 8'h00);
    rd(A_CTRL, v); check("R1 ctrl", v, 8'h00);
    rd(A_STAT, v); check("R1 stat", v, 8'h00);
    rd(A_FCTL, v); check("R1 fctl", v, 8'h00);
    rd(A_DATA, v); check("R1 data", v, 8'h00);
    wr(A_CTRL, 8'h10); push(8'h5A);
    rd(A_STAT, v); check("R1 default level 1", v, 8'h02);
    rd(A_DATA, v); check("R1 data", v, 8'h5A);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr(A_CTRL, 8'h00); push(8'h11);
    rd(A_DATA, v); check("R2 disabled drop", v, 8'h00);
    wr(A_CTRL, 8'h10);
    push(8'hA1); push(8'hA2); push(8'hA3);
    rd(A_DATA, v); check("R2 order 1", v, 8'hA1);
    rd(A_DATA, v); check("R2 order 2", v, 8'hA2);
    rd(A_DATA, v); check("R2 order 3", v, 8'hA3);
    rd(A_DATA, v); check("R11 empty read", v, 8'h00);
    push(8'hD1);
    rd(A_DATA, v); check("R11 after empty read", v, 8'hD1);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(A_CTRL, 8'hFF);
    rd(A_CTRL, v); check("R8 ctrl mask", v, 8'hFA);
    wr(A_CTRL, 8'h10);
  endtask

  task automatic t_trig;
    logic [7:0] v;
    int lv;
    for (int code = 0; code < 4; code++) begin
      lv = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      wr(A_FCTL, 8'((code << 6) | 2));
      rd(A_FCTL, v); check("R9 flush bit not kept", v, 8'(code << 6));
      for (int i = 0; i < lv - 1; i++) push(8'(8'h20 + i));
      rd(A_STAT, v); check("R4 below level", v, 8'h00);
      push(8'h7E);
      rd(A_STAT, v); check("R4 at level", v, 8'h02);
      if (code == 1) begin
        rd(A_DATA, v); check("R5 pop value", v, 8'h20);
        rd(A_STAT, v); check("R5 cleared below level", v, 8'h00);
        push(8'h7F);
        rd(A_STAT, v); check("R4 back at level", v, 8'h02);
      end
      wr(A_FCTL, 8'((code << 6) | 2));
      rd(A_STAT, v); check("R9 flush clears ready", v, 8'h00);
      rd(A_DATA, v); check("R9 flush empties", v, 8'h00);
    end
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(A_CTRL, 8'h50); wr(A_FCTL, 8'h02);
    push(8'h31);
    check("R6 irq raised", {7'd0, rx_irq}, 8'h01);
    rd(A_DATA, v); check("R6 pop", v, 8'h31);
    check("R6 irq held after drain", {7'd0, rx_irq}, 8'h01);
    rd(A_STAT, v); check("R5 ready cleared", v, 8'h00);
    wr(A_STAT, 8'h03);
    check("R7 ones keep irq", {7'd0, rx_irq}, 8'h01);
    wr(A_STAT, 8'h02);
    check("R7 bit0 zero clears irq", {7'd0, rx_irq}, 8'h00);
    push(8'h32);
    check("R6 irq again", {7'd0, rx_irq}, 8'h01);
    wr(A_CTRL, 8'h10);
    check("R8 rie zero clears irq", {7'd0, rx_irq}, 8'h00);
    push(8'h33);
    check("R6 no irq without enable", {7'd0, rx_irq}, 8'h00);
    rd(A_STAT, v); check("R7 ready before clear", v, 8'h02);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); check("R7 bit1 zero clears ready", v, 8'h00);
    rd(A_DATA, v); check("R7 data kept", v, 8'h32);
    wr(A_FCTL, 8'h02);
  endtask

  task automatic t_full;
    logic [7:0] v;
    wr(A_CTRL, 8'h10); wr(A_FCTL, 8'hC2);
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i));
    for (int i = 0; i < 5; i++) begin
      rd(A_DATA, v); check("R12 pre-fill", v, 8'(8'h40 + i));
    end
    for (int i = 0; i < 16; i++) push(8'(8'hB0 + i));
    push(8'hEE);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, v); check("R12 wrapped order", v, 8'(8'hB0 + i));
    end
    rd(A_DATA, v); check("R3 overflow byte dropped", v, 8'h00);
    wr(A_FCTL, 8'h02);
  endtask

  task automatic t_simul;
    logic [7:0] v;
    push(8'hC1); push(8'hC2); push(8'hC3);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'hC4; reg_sel = 1; reg_wr = 0; reg_addr = A_DATA;
    @(negedge clk);
    v = reg_rdata;
    rx_valid = 0; reg_sel = 0;
    check("R11 simultaneous pop", v, 8'hC1);
    rd(A_DATA, v); check("R11 rest 1", v, 8'hC2);
    rd(A_DATA, v); check("R11 rest 2", v, 8'hC3);
    rd(A_DATA, v); check("R11 rest 3", v, 8'hC4);
    rd(A_DATA, v); check("R11 count kept", v, 8'h00);
  endtask

  task automatic t_break;
    logic [7:0] v;
    @(negedge clk); rx_brk = 1;
    @(negedge clk); rx_brk = 0;
    rd(A_STAT, v); check("R10 break set", v, 8'h10);
    wr(A_STAT, 8'hFF);
    rd(A_STAT, v); check("R10 break kept", v, 8'h10);
    wr(A_STAT, 8'hEF);
    rd(A_STAT, v); check("R10 break cleared", v, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_enable();
    t_mask();
    t_trig();
    t_irq();
    t_full();
    t_simul();
    t_break();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule